// File: doc/BRIEF.md
# SIMD Lane Permute and Byte-Shift Unit

This block is a datapath stage for 128-bit vector operands. It rearranges data in one of three ways, chosen by a 3-bit operation code and steered by an 8-bit immediate. It can reorder fixed-width elements under control of the immediate. It can slide the whole register by a count of bytes. It can build a result from one 64-bit half of each of two operands.

Each operation accepted with `in_valid` produces one registered result. The result appears one clock later, together with `out_valid`. When no operation is accepted, the result register keeps its last value. The block has no flow control and no internal state apart from the result register.

Top module: `vperm_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it goes low, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. When `in_valid` is low, `result` holds its previous value.
- R3: Operation code 0 treats the source as four 32-bit lanes, lane 0 being the least significant. Result lane i is source lane `imm[2i+1:2i]`.
- R4: Operation code 1 treats source bits [63:0] as four 16-bit words. Result word i (i = 0..3) is the source word selected by `imm[2i+1:2i]`. Result bits [127:64] equal source bits [127:64].
- R5: Operation code 2 does the same as R4 on the four 16-bit words of source bits [127:64]. Result bits [63:0] equal source bits [63:0].
- R6: Operation code 3 shifts the whole source toward the most significant end by `imm` bytes and fills the vacated low bytes with zero. For any count of 16 or more, the result is all zeros.
- R7: Operation code 4 shifts the whole source toward the least significant end by `imm` bytes and fills the vacated high bytes with zero. For any count of 16 or more, the result is all zeros.
- R8: Operation code 5 gives result[63:0] = dst[127:64] and result[127:64] = src[127:64]. The immediate has no effect.
- R9: Operation code 6 gives result[63:0] = dst[63:0] and result[127:64] = src[63:0]. The immediate has no effect.
- R10: Operation code 7 gives an all-zero result, still strobed by `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept the operation on the inputs this cycle |
| op | input | 3 | Operation code (0..7, see R3 to R10) |
| imm | input | 8 | Lane selectors or byte-shift count |
| src | input | 128 | Source operand |
| dst | input | 128 | Second operand, used by the interleave operations |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Registered result |

## Verification
The bench aims at the selector fields. It uses a reversing pattern and a broadcast pattern, so a swapped or mis-indexed selector field puts the wrong lane into a known position. It checks the half-window word shuffles for the untouched half, which a wrong window offset would corrupt or zero. For the byte shifts it tests counts 0, 1, 15, 16 and 255: a design that ignored the top count bits would wrap around and leave stray bytes instead of zeros. For the interleaves it uses distinct source and second-operand patterns, so a swapped half ordering shows up at once.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

  localparam int VEC_W  = 128;
  localparam int IMM_W  = 8;
  localparam int OP_W   = 3;
  localparam int HALF_W = VEC_W / 2;
  localparam int BYTES  = VEC_W / 8;

  typedef enum logic [OP_W-1:0] {
    OP_SHUF_DW  = 3'd0,
    OP_SHUF_LOW = 3'd1,
    OP_SHUF_HIW = 3'd2,
    OP_BSL      = 3'd3,
    OP_BSR      = 3'd4,
    OP_MIX_HI   = 3'd5,
    OP_MIX_LO   = 3'd6,
    OP_NONE     = 3'd7
  } vperm_op_e;

  // Two-bit selector for output lane idx
  function automatic logic [1:0] lane_pick(input logic [IMM_W-1:0] imm, input int idx);
    return imm[2*idx +: 2];
  endfunction

endpackage

// File: rtl/vperm_shuffle.sv
module vperm_shuffle #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int WIN_LO = 0
) (
  input  logic [VEC_W-1:0] src,
  input  logic [7:0]       imm,
  output logic [VEC_W-1:0] res
);
  import vperm_pkg::*;

  localparam int LANES  = 4;
  localparam int WIN_W  = LANES * LANE_W;
  localparam int WIN_HI = WIN_LO + WIN_W;

  logic [LANE_W-1:0] win_lane [LANES];
  logic [LANE_W-1:0] pick_out [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign win_lane[g] = src[WIN_LO + g*LANE_W +: LANE_W];
    assign pick_out[g] = win_lane[lane_pick(imm, g)];
    assign res[WIN_LO + g*LANE_W +: LANE_W] = pick_out[g];
  end

  if (WIN_LO > 0) begin : g_keep_low
    assign res[WIN_LO-1:0] = src[WIN_LO-1:0];
  end

  if (WIN_HI < VEC_W) begin : g_keep_high
    assign res[VEC_W-1:WIN_HI] = src[VEC_W-1:WIN_HI];
  end

endmodule

// File: rtl/vperm_byteshift.sv
module vperm_byteshift #(
  parameter int VEC_W      = 128,
  parameter int CNT_W      = 8,
  parameter bit SHIFT_LEFT = 1'b1
) (
  input  logic [VEC_W-1:0] src,
  input  logic [CNT_W-1:0] cnt,
  output logic [VEC_W-1:0] res,
  output logic             over
);
  localparam int BYTES  = VEC_W / 8;
  localparam int STAGES = $clog2(BYTES);

  // Barrel of byte-granular stages, one per count bit below BYTES
  function automatic logic [VEC_W-1:0] move_bytes(input logic [VEC_W-1:0] v,
                                                  input logic [CNT_W-1:0] n);
    logic [VEC_W-1:0] r;
    r = v;
    for (int b = 0; b < STAGES; b++) begin
      if (n[b]) begin
        if (SHIFT_LEFT) r = r << (8 << b);
        else            r = r >> (8 << b);
      end
    end
    return r;
  endfunction

  assign over = (32'(cnt) >= BYTES);
  assign res  = over ? '0 : move_bytes(src, cnt);

endmodule

// File: rtl/vperm_merge.sv
module vperm_merge #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] src,
  input  logic [VEC_W-1:0] dst,
  input  logic             take_high,
  output logic [VEC_W-1:0] res
);
  localparam int HALF = VEC_W / 2;

  logic [HALF-1:0] src_half;
  logic [HALF-1:0] dst_half;

  assign src_half = take_high ? src[VEC_W-1:HALF] : src[HALF-1:0];
  assign dst_half = take_high ? dst[VEC_W-1:HALF] : dst[HALF-1:0];
  assign res      = {src_half, dst_half};

endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
  import vperm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [OP_W-1:0]    op,
  input  logic [IMM_W-1:0]   imm,
  input  logic [VEC_W-1:0]   src,
  input  logic [VEC_W-1:0]   dst,
  output logic               out_valid,
  output logic [VEC_W-1:0]   result
);

  logic [VEC_W-1:0] shuf_dw_res;
  logic [VEC_W-1:0] shuf_lo_res;
  logic [VEC_W-1:0] shuf_hi_res;
  logic [VEC_W-1:0] bsl_res;
  logic [VEC_W-1:0] bsr_res;
  logic [VEC_W-1:0] mix_res;
  logic             bsl_over;
  logic             bsr_over;
  logic             mix_high;
  logic [VEC_W-1:0] sel_result;

  vperm_shuffle #(.VEC_W(VEC_W), .LANE_W(32), .WIN_LO(0)) u_shuf_dw (
    .src(src), .imm(imm), .res(shuf_dw_res));

  vperm_shuffle #(.VEC_W(VEC_W), .LANE_W(16), .WIN_LO(0)) u_shuf_lo (
    .src(src), .imm(imm), .res(shuf_lo_res));

  vperm_shuffle #(.VEC_W(VEC_W), .LANE_W(16), .WIN_LO(HALF_W)) u_shuf_hi (
    .src(src), .imm(imm), .res(shuf_hi_res));

  vperm_byteshift #(.VEC_W(VEC_W), .CNT_W(IMM_W), .SHIFT_LEFT(1'b1)) u_bsl (
    .src(src), .cnt(imm), .res(bsl_res), .over(bsl_over));

  vperm_byteshift #(.VEC_W(VEC_W), .CNT_W(IMM_W), .SHIFT_LEFT(1'b0)) u_bsr (
    .src(src), .cnt(imm), .res(bsr_res), .over(bsr_over));

  assign mix_high = (op == OP_MIX_HI);

  vperm_merge #(.VEC_W(VEC_W)) u_merge (
    .src(src), .dst(dst), .take_high(mix_high), .res(mix_res));

  always_comb begin
    case (vperm_op_e'(op))
      OP_SHUF_DW:  sel_result = shuf_dw_res;
      OP_SHUF_LOW: sel_result = shuf_lo_res;
      OP_SHUF_HIW: sel_result = shuf_hi_res;
      OP_BSL:      sel_result = bsl_res;
      OP_BSR:      sel_result = bsr_res;
      OP_MIX_HI,
      OP_MIX_LO:   sel_result = mix_res;
      default:     sel_result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= sel_result;
    end
  end

  // R2: strobe follows the accept one cycle later
  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  // R2: no accept, no change
  assert_result_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  // R6: left shift by 16 or more clears everything
  assert_bsl_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BSL && 32'(imm) >= BYTES) |=> (result == '0));

  // R7: right shift by 16 or more clears everything
  assert_bsr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_BSR && 32'(imm) >= BYTES) |=> (result == '0));

  // R8: high interleave ordering
  assert_mix_hi_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_MIX_HI) |=>
      (result[HALF_W-1:0] == $past(dst[VEC_W-1:HALF_W]) &&
       result[VEC_W-1:HALF_W] == $past(src[VEC_W-1:HALF_W])));

  // R4: low-word shuffle leaves the upper half untouched
  assert_lowin_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_SHUF_LOW) |=>
      (result[VEC_W-1:HALF_W] == $past(src[VEC_W-1:HALF_W])));

  // R10: spare code yields zero
  assert_spare_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == OP_NONE) |=> (result == '0));

endmodule

// File: tb/test_vperm_unit.sv
`timescale 1ns/1ps
module test_vperm_unit;

  localparam logic [127:0] SRC = 128'h0f0e0d0c_0b0a0908_07060504_03020100;
  localparam logic [127:0] DST = 128'h8f8e8d8c_8b8a8988_87868584_83828180;
  localparam logic [127:0] ZRO = 128'h0;
  localparam int NV = 15;

  // {req[3:0], op[2:0], imm[7:0], src, dst, expected}
  localparam logic [398:0] VEC [NV] = '{
    {4'd3,  3'd0, 8'h1b, SRC, DST, 128'h03020100_07060504_0b0a0908_0f0e0d0c},
    {4'd3,  3'd0, 8'h00, SRC, DST, 128'h03020100_03020100_03020100_03020100},
    {4'd4,  3'd1, 8'h1b, SRC, DST, 128'h0f0e0d0c_0b0a0908_01000302_05040706},
    {4'd5,  3'd2, 8'h4e, SRC, DST, 128'h0b0a0908_0f0e0d0c_07060504_03020100},
    {4'd6,  3'd3, 8'h03, SRC, DST, 128'h0c0b0a09_08070605_04030201_00000000},
    {4'd6,  3'd3, 8'h01, SRC, DST, 128'h0e0d0c0b_0a090807_06050403_02010000},
    {4'd6,  3'd3, 8'h00, SRC, DST, SRC},
    {4'd6,  3'd3, 8'h10, SRC, DST, ZRO},
    {4'd6,  3'd3, 8'hff, SRC, DST, ZRO},
    {4'd7,  3'd4, 8'h05, SRC, DST, 128'h00000000_000f0e0d_0c0b0a09_08070605},
    {4'd7,  3'd4, 8'h0f, SRC, DST, 128'h00000000_00000000_00000000_0000000f},
    {4'd7,  3'd4, 8'h10, SRC, DST, ZRO},
    {4'd8,  3'd5, 8'hff, SRC, DST, 128'h0f0e0d0c_0b0a0908_8f8e8d8c_8b8a8988},
    {4'd9,  3'd6, 8'h5a, SRC, DST, 128'h07060504_03020100_87868584_83828180},
    {4'd10, 3'd7, 8'h00, SRC, DST, ZRO}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op;
  logic [7:0]   imm;
  logic [127:0] src;
  logic [127:0] dst;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  vperm_unit i_vperm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .imm(imm),
    .src(src), .dst(dst), .out_valid(out_valid), .result(result));

  function automatic string req_tag(input logic [3:0] n);
    case (n)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; imm = '0; src = '0; dst = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", {127'b0, out_valid}, 128'd0);
    check("R1 result in reset", result, ZRO);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      op  = VEC[i][394:392];
      imm = VEC[i][391:384];
      src = VEC[i][383:256];
      dst = VEC[i][255:128];
      @(negedge clk);
      check({req_tag(VEC[i][398:395]), " valid"}, {127'b0, out_valid}, 128'd1);
      check(req_tag(VEC[i][398:395]), result, VEC[i][127:0]);
    end

    // R2: idle cycles hold the result, strobe drops
    in_valid = 1'b0; op = 3'd0; imm = 8'h1b; src = DST; dst = SRC;
    @(negedge clk);
    check("R2 strobe low", {127'b0, out_valid}, 128'd0);
    check("R2 hold", result, ZRO);

    // R2 then R8: a new accept after idle, operands swapped
    in_valid = 1'b1; op = 3'd5; imm = 8'h00; src = DST; dst = SRC;
    @(negedge clk);
    check("R8 swapped operands", result, 128'h8f8e8d8c_8b8a8988_0f0e0d0c_0b0a0908);
    in_valid = 1'b0; src = SRC;
    @(negedge clk);
    check("R2 hold after idle", result, 128'h8f8e8d8c_8b8a8988_0f0e0d0c_0b0a0908);
    check("R2 strobe single", {127'b0, out_valid}, 128'd0);

    // R5: identity selector keeps source
    in_valid = 1'b1; op = 3'd2; imm = 8'he4; src = DST;
    @(negedge clk);
    check("R5 identity", result, DST);

    // R1: reset asserted mid-run clears result at once
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", result, ZRO);
    check("R1 reset strobe", {127'b0, out_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule